// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is a write-only serial slave that receives configuration for a radio front end over three wires: a serial clock, a serial data line and an active-low enable. While enable is low, each rising edge of the serial clock shifts one data bit in, most significant bit first. When enable returns high, the bit received last acts as an address. It selects which of two internal configuration words takes the shifted value. The two words differ in length and layout.

The serial pins are asynchronous to the block. They pass through two-flop synchronisers into a faster system clock, and all edge detection happens there. The block does not count clock pulses. Any leading bits beyond a word's length drop out of the shift register, and each word uses only the most recent bits. The outputs are the decoded fields of both words. These are the synthesiser divider codes, the oscillator select, the filter and compensation enables and scales, the pretune and charge-pump codes, the output-power code, a DAC code and a test code. Two fields are also given as signed step or dBm values.

Top module: `cfg3w_port`

## Requirements
- R1: After a synchronous reset, every latched field is zero, so the charge-pump step reads -1 and the power setting reads -21 dBm.
- R2: Bits are captured only on rising serial-clock edges while enable is low. Clock activity while enable is high leaves every output unchanged.
- R3: The last bit before enable rises is the address. A 1 updates word 1 from the last 24 bits received and leaves word 2 unchanged.
- R4: An address bit of 0 updates word 2 from the last 14 bits received and leaves word 1 unchanged.
- R5: Extra leading bits beyond a word's length are discarded. No check is made on the pulse count.
- R6: Word 1 frame fields, counted with frame bit 0 as the address:
  - [23:22] reference code
  - [21:17] swallow code
  - [16:14] main code
  - [13] oscillator select (1 = transmit)
  - [12] unused
  - [11] compensation enable
  - [10:8] deviation scale
  - [7:4] pretune code
  - [3:2] charge-pump code
  - [1] filter enable
- R7: Word 2 frame fields, counted with frame bit 0 as the address:
  - [13:12] power code
  - [11:7] DAC code
  - [6:4] compensation scale
  - [3:1] test code
- R8: The charge-pump step output is the signed value code - 1: 00 gives -1, 01 gives 0, 10 gives +1 and 11 gives +2.
- R9: The power output in dBm maps 00 to -21, 01 to -11, 10 to -4 and 11 to +3.
- R10: Latched fields change only in response to enable rising, never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_en_i | input | 1 | Active-low transfer enable; its rising edge latches |
| ref_code_o | output | 2 | Reference divider code |
| swallow_o | output | 5 | Swallow counter code |
| main_code_o | output | 3 | Main counter code |
| osc_tx_o | output | 1 | Oscillator select, 1 = transmit |
| comp_en_o | output | 1 | Modulation compensation enable |
| dev_scale_o | output | 3 | Deviation scale code |
| pretune_o | output | 4 | Oscillator pretune code |
| cp_code_o | output | 2 | Charge-pump current code |
| cp_step_o | output | 3 | Charge-pump step, signed |
| filt_en_o | output | 1 | Transmit filter enable |
| pwr_code_o | output | 2 | Output power code |
| pwr_dbm_o | output | 6 | Output power in dBm, signed |
| dac_code_o | output | 5 | Demodulator/ramp DAC code |
| comp_scale_o | output | 3 | Compensation scale code |
| test_code_o | output | 3 | Test/observation code |

## Verification
The assertions assume that each serial-clock level and each enable level lasts several system-clock cycles. With that margin, the synchronised data bit is settled at the detected rising edge, and a clock edge never merges with an enable edge. The stimulus holds every serial half-period for ten system cycles. It changes data only while the serial clock is low. It also leaves idle time after enable falls and between transfers, which keeps the inputs inside those assumptions.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

    localparam int W1_LEN = 24;
    localparam int W2_LEN = 14;
    localparam int SR_W   = (W1_LEN > W2_LEN) ? W1_LEN : W2_LEN;

    typedef enum logic {
        OSC_RX = 1'b0,
        OSC_TX = 1'b1
    } osc_sel_e;

    typedef struct packed {
        logic [1:0] ref_code;
        logic [4:0] swallow;
        logic [2:0] main_code;
        osc_sel_e   osc;
        logic       spare;
        logic       comp_en;
        logic [2:0] dev_scale;
        logic [3:0] pretune;
        logic [1:0] cp_code;
        logic       filt_en;
    } word1_t;

    typedef struct packed {
        logic [1:0] pwr_code;
        logic [4:0] dac_code;
        logic [2:0] comp_scale;
        logic [2:0] test_code;
    } word2_t;

    function automatic logic signed [2:0] cp_step(input logic [1:0] code);
        return $signed({1'b0, code}) - 3'sd1;
    endfunction

    function automatic logic signed [5:0] pwr_dbm(input logic [1:0] code);
        case (code)
            2'd0:    return -6'sd21;
            2'd1:    return -6'sd11;
            2'd2:    return -6'sd4;
            default: return 6'sd3;
        endcase
    endfunction

endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
    parameter int W       = 3,
    parameter int STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stage_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= RST_VAL;
                else     stage_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg3w_shifter.sv
module cfg3w_shifter
    import cfg3w_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sclk_s_i,
    input  logic            sdat_s_i,
    input  logic            sen_s_i,
    output logic [SR_W-1:0] frame_o,
    output logic            load_o
);
    logic            sclk_d, sen_d;
    logic [SR_W-1:0] sreg_q;
    logic            load_q;
    logic            sclk_rise;

    assign sclk_rise = sclk_s_i & ~sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            sen_d  <= 1'b1;
            sreg_q <= '0;
            load_q <= 1'b0;
        end else begin
            sclk_d <= sclk_s_i;
            sen_d  <= sen_s_i;
            if (sclk_rise && !sen_s_i)
                sreg_q <= {sreg_q[SR_W-2:0], sdat_s_i};
            load_q <= sen_s_i & ~sen_d;
        end
    end

    assign frame_o = sreg_q;
    assign load_o  = load_q;

    // R2
    sreg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sen_s_i |=> $stable(sreg_q));

    // R10
    load_single_chk: assert property (@(posedge clk) disable iff (rst)
        load_q |=> !load_q);
endmodule

// File: rtl/cfg3w_regs.sv
module cfg3w_regs
    import cfg3w_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [SR_W-1:0] frame_i,
    input  logic            load_i,
    output word1_t          w1_o,
    output word2_t          w2_o
);
    word1_t w1_q;
    word2_t w2_q;
    logic   addr;

    assign addr = frame_i[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            w1_q <= '0;
            w2_q <= '0;
        end else if (load_i) begin
            if (addr) w1_q <= word1_t'(frame_i[W1_LEN-1:1]);
            else      w2_q <= word2_t'(frame_i[W2_LEN-1:1]);
        end
    end

    assign w1_o = w1_q;
    assign w2_o = w2_q;

    // R10
    fields_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(w1_q) && $stable(w2_q)));

    // R3
    word2_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && frame_i[0]) |=> $stable(w2_q));

    // R4
    word1_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !frame_i[0]) |=> $stable(w1_q));
endmodule

// File: rtl/cfg3w_port.sv
module cfg3w_port
    import cfg3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    input  logic              ser_en_i,
    output logic [1:0]        ref_code_o,
    output logic [4:0]        swallow_o,
    output logic [2:0]        main_code_o,
    output logic              osc_tx_o,
    output logic              comp_en_o,
    output logic [2:0]        dev_scale_o,
    output logic [3:0]        pretune_o,
    output logic [1:0]        cp_code_o,
    output logic signed [2:0] cp_step_o,
    output logic              filt_en_o,
    output logic [1:0]        pwr_code_o,
    output logic signed [5:0] pwr_dbm_o,
    output logic [4:0]        dac_code_o,
    output logic [2:0]        comp_scale_o,
    output logic [2:0]        test_code_o
);
    logic [2:0]      pins_s;
    logic [SR_W-1:0] frame;
    logic            load;
    word1_t          w1;
    word2_t          w2;
    logic            unused_spare;

    cfg3w_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({ser_en_i, ser_data_i, ser_clk_i}),
        .q_o (pins_s)
    );

    cfg3w_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_s_i (pins_s[0]),
        .sdat_s_i (pins_s[1]),
        .sen_s_i  (pins_s[2]),
        .frame_o  (frame),
        .load_o   (load)
    );

    cfg3w_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .frame_i (frame),
        .load_i  (load),
        .w1_o    (w1),
        .w2_o    (w2)
    );

    assign unused_spare = w1.spare;

    assign ref_code_o   = w1.ref_code;
    assign swallow_o    = w1.swallow;
    assign main_code_o  = w1.main_code;
    assign osc_tx_o     = (w1.osc == OSC_TX);
    assign comp_en_o    = w1.comp_en;
    assign dev_scale_o  = w1.dev_scale;
    assign pretune_o    = w1.pretune;
    assign cp_code_o    = w1.cp_code;
    assign cp_step_o    = cp_step(w1.cp_code);
    assign filt_en_o    = w1.filt_en;
    assign pwr_code_o   = w2.pwr_code;
    assign pwr_dbm_o    = pwr_dbm(w2.pwr_code);
    assign dac_code_o   = w2.dac_code;
    assign comp_scale_o = w2.comp_scale;
    assign test_code_o  = w2.test_code;
endmodule

// File: tb/cfg3w_port_bench.sv
module cfg3w_port_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sdat = 1'b0, sen = 1'b1;

    logic [1:0] ref_code; logic [4:0] swallow; logic [2:0] main_code;
    logic osc_tx, comp_en, filt_en;
    logic [2:0] dev_scale; logic [3:0] pretune; logic [1:0] cp_code;
    logic signed [2:0] cp_step;
    logic [1:0] pwr_code; logic signed [5:0] pwr_dbm;
    logic [4:0] dac_code; logic [2:0] comp_scale, test_code;

    int n_checks = 0, n_fail = 0, cycles = 0;

    typedef struct {
        logic [22:0] e1;
        logic [12:0] e2;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    logic [22:0] cur1 = '0;
    logic [12:0] cur2 = '0;
    event xfer_done;

    always #4 clk = ~clk;

    cfg3w_port u_cfg3w_port (
        .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_data_i(sdat), .ser_en_i(sen),
        .ref_code_o(ref_code), .swallow_o(swallow), .main_code_o(main_code),
        .osc_tx_o(osc_tx), .comp_en_o(comp_en), .dev_scale_o(dev_scale),
        .pretune_o(pretune), .cp_code_o(cp_code), .cp_step_o(cp_step),
        .filt_en_o(filt_en), .pwr_code_o(pwr_code), .pwr_dbm_o(pwr_dbm),
        .dac_code_o(dac_code), .comp_scale_o(comp_scale), .test_code_o(test_code)
    );

    task automatic check(input string what, input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int dbm_of(input logic [1:0] c);
        case (c)
            2'd0: return -21;
            2'd1: return -11;
            2'd2: return -4;
            default: return 3;
        endcase
    endfunction

    // compare all outputs against an expected image (frame bit k = image bit k-1)
    task automatic compare(input exp_t x);
        check("ref",     {x.req, "/R6"}, int'(ref_code),   int'(x.e1[22:21]));
        check("swallow", {x.req, "/R6"}, int'(swallow),    int'(x.e1[20:16]));
        check("main",    {x.req, "/R6"}, int'(main_code),  int'(x.e1[15:13]));
        check("osc",     {x.req, "/R6"}, int'(osc_tx),     int'(x.e1[12]));
        check("comp_en", {x.req, "/R6"}, int'(comp_en),    int'(x.e1[10]));
        check("dev",     {x.req, "/R6"}, int'(dev_scale),  int'(x.e1[9:7]));
        check("pretune", {x.req, "/R6"}, int'(pretune),    int'(x.e1[6:3]));
        check("cp_code", {x.req, "/R6"}, int'(cp_code),    int'(x.e1[2:1]));
        check("filt",    {x.req, "/R6"}, int'(filt_en),    int'(x.e1[0]));
        check("cp_step", {x.req, "/R8"}, int'(cp_step),    int'(x.e1[2:1]) - 1);
        check("pwr",     {x.req, "/R7"}, int'(pwr_code),   int'(x.e2[12:11]));
        check("dbm",     {x.req, "/R9"}, int'(pwr_dbm),    dbm_of(x.e2[12:11]));
        check("dac",     {x.req, "/R7"}, int'(dac_code),   int'(x.e2[10:6]));
        check("cscale",  {x.req, "/R7"}, int'(comp_scale), int'(x.e2[5:3]));
        check("test",    {x.req, "/R7"}, int'(test_code),  int'(x.e2[2:0]));
    endtask

    // monitor: pops one expected image per completed transfer
    initial begin
        forever begin
            @(xfer_done);
            if (exp_q.size() == 0) check("queue", "R10", 0, 1);
            else compare(exp_q.pop_front());
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ser_send(input logic [63:0] v, input int n);
        wait_cyc(1);
        sen = 1'b0;
        wait_cyc(26);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = v[i];
            wait_cyc(10);
            sclk = 1'b1;
            wait_cyc(10);
            sclk = 1'b0;
        end
        wait_cyc(10);
        sen = 1'b1;
        wait_cyc(34);
        -> xfer_done;
        wait_cyc(1);
    endtask

    function automatic logic [22:0] img1(input logic [1:0] r, input logic [4:0] sw,
        input logic [2:0] mn, input logic osc, input logic ce, input logic [2:0] dv,
        input logic [3:0] pt, input logic [1:0] cp, input logic gf);
        return {r, sw, mn, osc, 1'b0, ce, dv, pt, cp, gf};
    endfunction

    // word 1 transfer with optional junk leading bits (R3, R5)
    task automatic send1(input logic [22:0] im, input int junk_n, input logic [63:0] junk, input string req);
        logic [63:0] v;
        cur1 = im;
        exp_q.push_back('{cur1, cur2, req});
        v = (junk << 24) | {40'd0, im, 1'b1};
        ser_send(v, 24 + junk_n);
    endtask

    task automatic send2(input logic [12:0] im, input int junk_n, input logic [63:0] junk, input string req);
        logic [63:0] v;
        cur2 = im;
        exp_q.push_back('{cur1, cur2, req});
        v = (junk << 14) | {50'd0, im, 1'b0};
        ser_send(v, 14 + junk_n);
    endtask

    initial begin
        wait_cyc(6);
        rst = 1'b0;
        wait_cyc(4);
        // R1: reset state
        exp_q.push_back('{23'd0, 13'd0, "R1"});
        -> xfer_done;
        wait_cyc(1);

        // R3: word 1, word 2 untouched
        send1(img1(2'b10, 5'd27, 3'd5, 1'b1, 1'b1, 3'd6, 4'd9, 2'b01, 1'b1), 0, 0, "R3");
        // R4: word 2, word 1 untouched
        send2({2'b11, 5'd21, 3'd3, 3'd5}, 0, 0, "R4");
        send1(img1(2'b01, 5'd4, 3'd2, 1'b0, 1'b0, 3'd1, 4'd6, 2'b10, 1'b0), 0, 0, "R3");
        send1(23'h7FFFFF, 0, 0, "R6");
        send2(13'h1FFF, 0, 0, "R7");
        send2(13'h0AAA, 0, 0, "R7");

        // R5: extra leading bits discarded
        send1(img1(2'b11, 5'd1, 3'd7, 1'b0, 1'b1, 3'd2, 4'd15, 2'b00, 1'b1), 7, 64'h55, "R5");
        send2({2'b01, 5'd9, 3'd6, 3'd2}, 12, 64'hFFF, "R5");

        // R2: clock activity with enable high changes nothing
        for (int i = 0; i < 8; i++) begin
            sdat = i[0];
            wait_cyc(10);
            sclk = 1'b1;
            wait_cyc(10);
            sclk = 1'b0;
        end
        wait_cyc(30);
        exp_q.push_back('{cur1, cur2, "R2"});
        -> xfer_done;
        wait_cyc(1);

        // R8 / R9: all code values
        for (int c = 0; c < 4; c++) begin
            send1(img1(2'b00, 5'd3, 3'd1, 1'b1, 1'b0, 3'd4, 4'd8, c[1:0], 1'b0), 0, 0, "R8");
            send2({c[1:0], 5'd17, 3'd1, 3'd6}, 0, 0, "R9");
        end

        wait_cyc(4);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", cycles, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule